// File: doc/BRIEF.md
# External Bus Idle-Cycle Inserter

This block decides, for every new external bus access, whether one idle state must be placed ahead of the first real bus state. It then steps through the states of that access and reports one state code per clock. The decision looks at two accesses: the one that is ending in the current cycle, and the one being requested. For each it considers the direction, the target area and whether the target is DRAM. Three configuration inputs also take part: an idle-on-write-after-read enable, an idle-on-read-to-new-area enable, and a flag that says the DRAM column strobes share pins with the write strobes.

The idle state keeps the bus quiet for one clock, with no read strobe, no write strobe and no chip select. A slow device that is still releasing the data bus then cannot clash with the next driver. When CAS and write strobes share pins, the idle state also stops those shared pins and the next chip select from changing together. DRAM accesses open with a precharge state instead of an idle state. A request is taken when it is presented in a cycle where the block is ready. The request fields and the configuration inputs are sampled at that clock edge.

Top module: `bus_gap_seq`

## Requirements
- R1: After reset `bus_state` is FREE (code 0), `rd_en`, `wr_en` and `cs_en` are all zero, and `req_ready` is 1.
- R2: An access that is taken runs T1 (code 3) and then T2 (code 4). It adds T3 (code 5) when `req_long` was 1. A DRAM access (`req_dram`=1) first passes through Tp (code 2). With no new request, the cycle after the last state is FREE.
- R3: With `cfg_idle_war`=1, a non-DRAM write that directly follows a read starts with one Ti (code 1). With `cfg_idle_war`=0 this rule adds nothing.
- R4: With `cfg_idle_rr`=1, a non-DRAM read that directly follows a read to a different area starts with one Ti. A read to the same area never gets a Ti from this rule.
- R5: When a DRAM access is directly followed by a non-DRAM access and `cfg_cas_on_wr`=1, one Ti is inserted whatever the two idle enables are. With `cfg_cas_on_wr`=0 the DRAM history alone inserts nothing.
- R6: An access whose target is DRAM never starts with Ti, whatever the history and configuration. It starts with Tp.
- R7: At most one Ti is inserted per transition, even when several rules apply together.
- R8: The first access after reset, and any access that follows one or more FREE cycles, gets no Ti.
- R9: In Ti and Tp, `rd_en`, `wr_en` and `cs_en` are all zero. `rd_en` is 1 in T1 to T3 of a read. `wr_en` is 1 in T2 and T3 of a write. `cs_en` has only bit `area` set in T1 to T3.
- R10: `req_ready` is 1 exactly in FREE and in the last state of an access. A request present with `req_ready`=1 is taken at that edge, and its first state shows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | AREA_W | Target area number |
| req_dram | input | 1 | Target area is DRAM |
| req_long | input | 1 | Access uses a third state T3 |
| cfg_idle_war | input | 1 | Enables idle on write after read |
| cfg_idle_rr | input | 1 | Enables idle on read after read to another area |
| cfg_cas_on_wr | input | 1 | CAS strobes share the write strobe pins |
| req_ready | output | 1 | Request is taken at the next edge if present |
| bus_state | output | 3 | State code: 0 FREE, 1 Ti, 2 Tp, 3 T1, 4 T2, 5 T3 |
| rd_en | output | 1 | Read strobe enable |
| wr_en | output | 1 | Write strobe enable |
| cs_en | output | 2**AREA_W | One-hot chip select enable |

## Verification
The bench targets the transitions where the history matters. One case is a DRAM access followed by an external one with both idle enables off: a design that ignores the pin-sharing flag would leave out the forced Ti. Another is an external read followed by a DRAM read to another area: a design that ranks the idle rules above precharge would emit Ti before Tp. The bench also applies all rules at once to catch a doubled Ti. It puts a FREE gap before a write after read, where stale history would add a Ti that should not be there. Random streams mix long accesses with changing configuration. This exposes a ready signal raised in T2 of a long access, or strobes that leak into Ti or Tp.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

  typedef enum logic [2:0] {
    ST_FREE = 3'd0,
    ST_TI   = 3'd1,
    ST_TP   = 3'd2,
    ST_T1   = 3'd3,
    ST_T2   = 3'd4,
    ST_T3   = 3'd5
  } bus_state_e;

  // Gap rule: history must exist and the next target must not be DRAM.
  function automatic logic gap_needed(
    input logic have_prev,
    input logic prev_wr,
    input logic prev_dram,
    input logic same_area,
    input logic next_wr,
    input logic next_dram,
    input logic war_en,
    input logic rr_en,
    input logic cas_shared
  );
    logic hit;
    hit = 1'b0;
    if (have_prev && !next_dram) begin
      if (prev_dram && cas_shared)                hit = 1'b1;
      if (war_en && !prev_wr && next_wr)          hit = 1'b1;
      if (rr_en && !prev_wr && !next_wr && !same_area) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic ends_access(input bus_state_e s, input logic long_acc);
    return (s == ST_T3) || ((s == ST_T2) && !long_acc);
  endfunction

  function automatic bus_state_e first_state(input logic gap, input logic dram);
    if (gap)  return ST_TI;
    if (dram) return ST_TP;
    return ST_T1;
  endfunction

endpackage

// File: rtl/bgs_gap_decide.sv
module bgs_gap_decide #(
  parameter int unsigned AREA_W = 3
) (
  input  logic              have_prev,
  input  logic              prev_wr,
  input  logic              prev_dram,
  input  logic [AREA_W-1:0] prev_area,
  input  logic              next_wr,
  input  logic              next_dram,
  input  logic [AREA_W-1:0] next_area,
  input  logic              cfg_idle_war,
  input  logic              cfg_idle_rr,
  input  logic              cfg_cas_on_wr,
  output logic              need_gap,
  output logic              cas_hit,
  output logic              war_hit,
  output logic              rr_hit
);
  import bgs_pkg::*;

  logic same_area;
  assign same_area = (prev_area == next_area);

  assign need_gap = gap_needed(have_prev, prev_wr, prev_dram, same_area,
                               next_wr, next_dram, cfg_idle_war, cfg_idle_rr,
                               cfg_cas_on_wr);

  // Individual rule events, brought out for the checker.
  assign cas_hit = have_prev && !next_dram && prev_dram && cfg_cas_on_wr;
  assign war_hit = have_prev && !next_dram && cfg_idle_war && !prev_wr && next_wr;
  assign rr_hit  = have_prev && !next_dram && cfg_idle_rr && !prev_wr && !next_wr && !same_area;
endmodule

// File: rtl/bgs_seq.sv
module bgs_seq #(
  parameter int unsigned AREA_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AREA_W-1:0]     req_area,
  input  logic                  req_dram,
  input  logic                  req_long,
  input  logic                  need_gap,
  output logic                  req_ready,
  output logic                  acc_take,
  output bgs_pkg::bus_state_e   cur_state,
  output logic                  held_valid,
  output logic                  held_wr,
  output logic [AREA_W-1:0]     held_area,
  output logic                  held_dram
);
  import bgs_pkg::*;

  logic held_long;

  assign req_ready = (cur_state == ST_FREE) || ends_access(cur_state, held_long);
  assign acc_take  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_state  <= ST_FREE;
      held_valid <= 1'b0;
      held_wr    <= 1'b0;
      held_area  <= '0;
      held_dram  <= 1'b0;
      held_long  <= 1'b0;
    end else if (acc_take) begin
      cur_state  <= first_state(need_gap, req_dram);
      held_valid <= 1'b1;
      held_wr    <= req_write;
      held_area  <= req_area;
      held_dram  <= req_dram;
      held_long  <= req_long;
    end else begin
      case (cur_state)
        ST_TI:   cur_state <= held_dram ? ST_TP : ST_T1;
        ST_TP:   cur_state <= ST_T1;
        ST_T1:   cur_state <= ST_T2;
        ST_T2: begin
          if (held_long) begin
            cur_state <= ST_T3;
          end else begin
            cur_state  <= ST_FREE;
            held_valid <= 1'b0;
          end
        end
        ST_T3: begin
          cur_state  <= ST_FREE;
          held_valid <= 1'b0;
        end
        default: cur_state <= ST_FREE;
      endcase
    end
  end
endmodule

// File: rtl/bgs_strobe.sv
module bgs_strobe #(
  parameter int unsigned AREA_W = 3
) (
  input  bgs_pkg::bus_state_e    cur_state,
  input  logic                   held_wr,
  input  logic [AREA_W-1:0]      held_area,
  output logic                   rd_en,
  output logic                   wr_en,
  output logic [(1<<AREA_W)-1:0] cs_en
);
  import bgs_pkg::*;

  localparam int unsigned NUM_AREAS = 1 << AREA_W;

  logic in_data;
  logic in_write_win;

  assign in_data      = (cur_state == ST_T1) || (cur_state == ST_T2) || (cur_state == ST_T3);
  assign in_write_win = (cur_state == ST_T2) || (cur_state == ST_T3);

  assign rd_en = in_data && !held_wr;
  assign wr_en = in_write_win && held_wr;

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_cs
    assign cs_en[i] = in_data && (held_area == AREA_W'(i));
  end
endmodule

// File: rtl/bus_gap_seq.sv
module bus_gap_seq #(
  parameter int unsigned AREA_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [AREA_W-1:0]      req_area,
  input  logic                   req_dram,
  input  logic                   req_long,
  input  logic                   cfg_idle_war,
  input  logic                   cfg_idle_rr,
  input  logic                   cfg_cas_on_wr,
  output logic                   req_ready,
  output logic [2:0]             bus_state,
  output logic                   rd_en,
  output logic                   wr_en,
  output logic [(1<<AREA_W)-1:0] cs_en
);
  import bgs_pkg::*;

  bus_state_e        cur_state;
  logic              acc_take;
  logic              need_gap;
  logic              cas_hit;
  logic              war_hit;
  logic              rr_hit;
  logic              held_valid;
  logic              held_wr;
  logic [AREA_W-1:0] held_area;
  logic              held_dram;

  bgs_gap_decide #(.AREA_W(AREA_W)) u_decide (
    .have_prev     (held_valid),
    .prev_wr       (held_wr),
    .prev_dram     (held_dram),
    .prev_area     (held_area),
    .next_wr       (req_write),
    .next_dram     (req_dram),
    .next_area     (req_area),
    .cfg_idle_war  (cfg_idle_war),
    .cfg_idle_rr   (cfg_idle_rr),
    .cfg_cas_on_wr (cfg_cas_on_wr),
    .need_gap      (need_gap),
    .cas_hit       (cas_hit),
    .war_hit       (war_hit),
    .rr_hit        (rr_hit)
  );

  bgs_seq #(.AREA_W(AREA_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_area   (req_area),
    .req_dram   (req_dram),
    .req_long   (req_long),
    .need_gap   (need_gap),
    .req_ready  (req_ready),
    .acc_take   (acc_take),
    .cur_state  (cur_state),
    .held_valid (held_valid),
    .held_wr    (held_wr),
    .held_area  (held_area),
    .held_dram  (held_dram)
  );

  bgs_strobe #(.AREA_W(AREA_W)) u_strobe (
    .cur_state (cur_state),
    .held_wr   (held_wr),
    .held_area (held_area),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .cs_en     (cs_en)
  );

  assign bus_state = cur_state;
endmodule

// File: rtl/bus_gap_seq_chk.sv
module bus_gap_seq_chk #(
  parameter int unsigned AREA_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_dram,
  input logic                   req_ready,
  input logic [2:0]             bus_state,
  input logic                   rd_en,
  input logic                   wr_en,
  input logic [(1<<AREA_W)-1:0] cs_en,
  input logic                   acc_take,
  input logic                   cas_hit,
  input logic                   war_hit,
  input logic                   rr_hit
);
  localparam logic [2:0] C_FREE = 3'd0;
  localparam logic [2:0] C_TI   = 3'd1;
  localparam logic [2:0] C_TP   = 3'd2;
  localparam logic [2:0] C_T1   = 3'd3;
  localparam logic [2:0] C_T2   = 3'd4;

  // R9
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == C_TI || bus_state == C_TP) |-> (!rd_en && !wr_en && cs_en == '0));

  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_en));

  // R7
  single_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == C_TI) |=> (bus_state != C_TI));

  // R2
  t1_then_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == C_T1) |=> (bus_state == C_T2));

  // R6
  dram_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && req_dram) |=> (bus_state == C_TP));

  // R5
  cas_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && cas_hit) |=> (bus_state == C_TI));

  // R3
  war_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && war_hit) |=> (bus_state == C_TI));

  // R4
  rr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_take && rr_hit) |=> (bus_state == C_TI));

  // R8
  free_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == C_FREE && req_valid) |=> (bus_state != C_TI));

  // R10
  take_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_state != C_FREE));
endmodule

bind bus_gap_seq bus_gap_seq_chk #(.AREA_W(AREA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_dram  (req_dram),
  .req_ready (req_ready),
  .bus_state (bus_state),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .cs_en     (cs_en),
  .acc_take  (acc_take),
  .cas_hit   (cas_hit),
  .war_hit   (war_hit),
  .rr_hit    (rr_hit)
);

// File: tb/bus_gap_seq_tb.sv
`timescale 1ns/100ps
module bus_gap_seq_tb;
  localparam int unsigned AREA_W = 3;
  localparam int unsigned NA = 1 << AREA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_dram = 1'b0, req_long = 1'b0;
  logic [AREA_W-1:0] req_area = '0;
  logic cfg_idle_war = 1'b0, cfg_idle_rr = 1'b0, cfg_cas_on_wr = 1'b0;
  logic req_ready, rd_en, wr_en;
  logic [2:0] bus_state;
  logic [NA-1:0] cs_en;

  int n_checks = 0;
  int n_fail = 0;

  // bench-side history of the previous access
  bit h_some = 1'b0, h_wr = 1'b0, h_dram = 1'b0;
  int h_area = 0;

  always #2.5 clk = ~clk;

  bus_gap_seq #(.AREA_W(AREA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_area(req_area), .req_dram(req_dram), .req_long(req_long),
    .cfg_idle_war(cfg_idle_war), .cfg_idle_rr(cfg_idle_rr), .cfg_cas_on_wr(cfg_cas_on_wr),
    .req_ready(req_ready), .bus_state(bus_state), .rd_en(rd_en), .wr_en(wr_en), .cs_en(cs_en)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected idle decision, restated from the requirements R3, R4, R5, R6, R8.
  function automatic bit want_idle(bit nw, int na, bit nd, bit war, bit rr, bit cas);
    bit from_cas, from_war, from_rr;
    if (!h_some || nd) return 1'b0;
    from_cas = h_dram && cas;
    from_war = war && !h_wr && nw;
    from_rr  = rr && !h_wr && !nw && (h_area != na);
    return from_cas | from_war | from_rr;
  endfunction

  function automatic string why(bit nw, int na, bit nd, bit war, bit rr, bit cas);
    if (!h_some) return "R8";
    if (nd) return "R6";
    if (h_dram && cas) return "R5";
    if (war && !h_wr && nw) return "R3";
    if (rr && !h_wr && !nw && h_area != na) return "R4";
    return "R2";
  endfunction

  // Entered at a negedge in FREE or in the last state of the previous access.
  task automatic run_acc(bit nw, int na, bit nd, bit lng, int gap, bit war, bit rr, bit cas);
    int exp_seq[5];
    int n;
    bit g;
    string tag;
    if (gap > 0) begin
      req_valid = 1'b0;
      for (int k = 0; k < gap; k++) begin
        @(negedge clk);
        check("R2", "state in gap", bus_state, 0);
        check("R10", "ready in gap", req_ready, 1);
      end
      h_some = 1'b0;
    end
    cfg_idle_war = war; cfg_idle_rr = rr; cfg_cas_on_wr = cas;
    req_write = nw; req_area = AREA_W'(na); req_dram = nd; req_long = lng;
    req_valid = 1'b1;
    check("R10", "ready before take", req_ready, 1);
    g = want_idle(nw, na, nd, war, rr, cas);
    tag = why(nw, na, nd, war, rr, cas);
    n = 0;
    if (g)  begin exp_seq[n] = 1; n++; end
    if (nd) begin exp_seq[n] = 2; n++; end
    exp_seq[n] = 3; n++;
    exp_seq[n] = 4; n++;
    if (lng) begin exp_seq[n] = 5; n++; end
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'($urandom); req_area = AREA_W'($urandom); req_dram = 1'($urandom);
    req_long = 1'($urandom);
    cfg_idle_war = 1'($urandom); cfg_idle_rr = 1'($urandom); cfg_cas_on_wr = 1'($urandom);
    for (int k = 0; k < n; k++) begin
      int s;
      bit data_st, wr_st;
      s = exp_seq[k];
      data_st = (s >= 3);
      wr_st = (s >= 4);
      check(tag, "state code", bus_state, s);
      check("R9", "rd_en", rd_en, int'(data_st && !nw));
      check("R9", "wr_en", wr_en, int'(wr_st && nw));
      check("R9", "cs_en", int'(cs_en), data_st ? (1 << na) : 0);
      check("R10", "ready", req_ready, int'(k == n - 1));
      if (k != n - 1) @(negedge clk);
    end
    h_some = 1'b1; h_wr = nw; h_area = na; h_dram = nd;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "state", bus_state, 0);
    check("R1", "rd_en", rd_en, 0);
    check("R1", "wr_en", wr_en, 0);
    check("R1", "cs_en", int'(cs_en), 0);
    check("R1", "ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 first access after reset
    run_acc(0, 1, 0, 0, 0, 1, 1, 1);
    // R3 write after read with idle
    run_acc(1, 1, 0, 0, 0, 1, 0, 0);
    // R3 disabled: read then write with no idle
    run_acc(0, 2, 0, 1, 0, 0, 0, 0);
    run_acc(1, 2, 0, 0, 0, 0, 0, 0);
    // R4 same area no idle, then different area idle
    run_acc(0, 2, 0, 0, 0, 0, 1, 0);
    run_acc(0, 2, 0, 0, 0, 0, 1, 0);
    run_acc(0, 5, 0, 1, 0, 0, 1, 0);
    // R5 DRAM then external, both enables off, pins shared
    run_acc(0, 4, 1, 0, 0, 0, 0, 1);
    run_acc(1, 6, 0, 0, 0, 0, 0, 1);
    // R5 not shared: no idle
    run_acc(1, 4, 1, 0, 0, 0, 0, 0);
    run_acc(1, 6, 0, 0, 0, 0, 0, 0);
    // R6 read then DRAM read to another area: Tp, no Ti
    run_acc(0, 1, 0, 0, 0, 1, 1, 1);
    run_acc(0, 3, 1, 0, 0, 1, 1, 1);
    // R6 DRAM back to back
    run_acc(1, 3, 1, 1, 0, 1, 1, 1);
    // R7 every rule at once: DRAM read then external write
    run_acc(0, 3, 1, 0, 0, 1, 1, 1);
    run_acc(1, 0, 0, 0, 0, 1, 1, 1);
    // R8 gap before write after read
    run_acc(0, 7, 0, 0, 0, 1, 1, 1);
    run_acc(1, 7, 0, 0, 2, 1, 1, 1);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int gp;
      gp = ($urandom % 5 == 0) ? int'($urandom % 3) + 1 : 0;
      run_acc(1'($urandom), int'($urandom % NA), ($urandom % 4 == 0), 1'($urandom), gp,
              1'($urandom), 1'($urandom), 1'($urandom));
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R2", "state after last", bus_state, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule